// File: doc/BRIEF.md
# Superfractional UART Bit-Period Generator

This block produces the bit timing for an asynchronous serial transmitter or receiver. A frame-start pulse opens a frame. From then on the block emits a one-cycle strobe at the end of every bit slot and reports the index of the slot being timed.

Each slot is normally `16*(P+1)` clock cycles long, where P is the integer prescaler. A 4-bit fractional value M stretches M out of every 16 slots by one cycle. A 3-bit modulation code U stretches selected slots by one more cycle. Which slots are stretched depends only on the slot's position in the frame, through a ten-entry position table. Positions beyond the tenth fold back onto that table. The extra cycles average an additional fraction of a clock into the baud rate.

A prescaler of zero forces a fixed 32-cycle slot. Configuration is captured only when a frame starts.

Top module: `sfrac_baud_gen`

## Requirements
- R1: With P not 0, M = 0 and U = 0, every slot lasts exactly 16*(P+1) clock cycles. The count runs from the frame-start cycle, or from the previous strobe, up to and including the cycle in which `bit_end_o` is high.
- R2: With P = 0, every slot lasts 32 cycles whatever M and U are.
- R3: With P not 0, slot j of a frame (j counted from 0 at frame start, with no saturation) gets one extra cycle exactly when floor((j+1)*M/16) > floor(j*M/16).
- R4: With P not 0, a slot at table position e gets one further extra cycle when the entry for U at e is set. The set positions for each U are:
  - U=1: 0 and 8
  - U=2: 0, 4 and 8
  - U=3: 0, 2, 4 and 8
  - U=4: 0, 2, 4, 6 and 8
  - U=5: 0, 1, 2, 4, 6, 8 and 9
  - U=6: 0, 1, 2, 4, 5, 6, 8 and 9
  - U=7: every position 0 to 9 except 7
  - U=0: no positions
  The R3 and R4 extras add, so a slot can be up to two cycles longer.
- R5: Slot positions 10 to 12 use table positions 2 to 4 (position k uses table position k-8).
- R6: `bit_idx_o` is 0 after a frame start and rises by one at each strobe. It saturates at L-1, where L is the frame length `frame_len_i` (valid range 3 to 13). Slots timed while saturated use the position L-1.
- R7: P, M, U and L are captured on the frame-start pulse. Changing them mid-frame does not alter the slots of the running frame.
- R8: A frame-start pulse that falls in a strobe cycle suppresses that strobe. The new frame then begins, with index 0 and the newly captured configuration.
- R9: While `en_i` is low the cycle count holds and no strobe is emitted; each stalled cycle lengthens the current slot by one.
- R10: After reset, and until the first frame start, `bit_end_o` stays low and `bit_idx_o` is 0.

Throughout, `frame_start_i` takes effect regardless of `en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Count enable |
| frame_start_i | input | 1 | One-cycle pulse opening a frame |
| presc_i | input | PRESC_W | Integer prescaler P |
| frac_i | input | 4 | Fractional value M |
| mod_i | input | 3 | Modulation code U |
| frame_len_i | input | IDX_W | Slots per frame L, 3 to 13 |
| bit_end_o | output | 1 | End-of-slot strobe |
| bit_idx_o | output | IDX_W | Index of the slot being timed |

## Verification
A frame-start pulse and a slot-end strobe can land in the same cycle. The bench lets a 32-cycle slot run to its final cycle and raises the start pulse, with a new prescaler, exactly there. It then expects the strobe to be low in that cycle, the index to read 0 afterwards, and the next slot to last the 48 cycles of the new prescaler. A second collision, in which the fractional and modulation extras fall on the same slot, is judged by the two-cycle stretch that the bench's own period model predicts.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam int unsigned FRAC_W   = 4;
  localparam int unsigned MOD_W    = 3;
  localparam int unsigned TBL_N    = 10;
  localparam int unsigned FOLD_OFS = 8;
  localparam int unsigned P0_SLOT  = 32;

  // bit e set: table position e gets one extra cycle
  function automatic logic [TBL_N-1:0] mod_mask(input logic [MOD_W-1:0] u);
    case (u)
      3'd1:    return 10'h101;
      3'd2:    return 10'h111;
      3'd3:    return 10'h115;
      3'd4:    return 10'h155;
      3'd5:    return 10'h357;
      3'd6:    return 10'h377;
      3'd7:    return 10'h37f;
      default: return 10'h000;
    endcase
  endfunction
endpackage

// File: rtl/sfb_mod_table.sv
module sfb_mod_table
  import sfb_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [MOD_W-1:0] mod_i,
  input  logic [IDX_W-1:0] pos_i,
  output logic             extra_o
);
  localparam int unsigned NPOS = 2 ** IDX_W;

  logic [TBL_N-1:0] mask;
  logic [NPOS-1:0]  hit;

  assign mask = mod_mask(mod_i);

  for (genvar k = 0; k < NPOS; k++) begin : g_pos
    localparam int unsigned FOLD = (k < TBL_N) ? k : ((k - FOLD_OFS) % TBL_N);
    assign hit[k] = mask[FOLD];
  end

  assign extra_o = hit[pos_i];

  always_comb begin
    if (mod_i == '0) assert_no_mod_at_zero_R4: assert (!extra_o);
  end
endmodule

// File: rtl/sfb_frac_acc.sv
module sfb_frac_acc
  import sfb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (step_i) acc_q <= sum[FRAC_W-1:0];
  end

  assert_zero_frac_no_carry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_i == '0) |-> !carry_o);
  assert_clear_empties_acc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
endmodule

// File: rtl/sfb_pos_ctr.sv
module sfb_pos_ctr #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        idx_q <= '0;
    else if (clr_i)                     idx_q <= '0;
    else if (step_i && idx_q != last_i) idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  assert_idx_saturates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && idx_q == last_i) |=> (idx_q == $past(idx_q)));
  assert_idx_advances_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && idx_q != last_i) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/sfrac_baud_gen.sv
module sfrac_baud_gen
  import sfb_pkg::*;
#(
  parameter int unsigned PRESC_W = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               frame_start_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [FRAC_W-1:0]  frac_i,
  input  logic [MOD_W-1:0]   mod_i,
  input  logic [IDX_W-1:0]   frame_len_i,
  output logic               bit_end_o,
  output logic [IDX_W-1:0]   bit_idx_o
);
  localparam int unsigned CNT_W = PRESC_W + FRAC_W + 2;

  logic               active_q;
  logic [PRESC_W-1:0] p_q;
  logic [FRAC_W-1:0]  m_q;
  logic [MOD_W-1:0]   u_q;
  logic [IDX_W-1:0]   len_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   last_cnt;
  logic               frac_extra;
  logic               mod_extra;
  logic               tick;
  logic               bit_end;
  logic [IDX_W-1:0]   idx;

  sfb_frac_acc i_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_start_i),
    .step_i (bit_end),
    .frac_i (m_q),
    .carry_o(frac_extra)
  );

  sfb_mod_table #(.IDX_W(IDX_W)) i_mod (
    .mod_i  (u_q),
    .pos_i  (idx),
    .extra_o(mod_extra)
  );

  sfb_pos_ctr #(.IDX_W(IDX_W)) i_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_start_i),
    .step_i (bit_end),
    .last_i (len_q - 1'b1),
    .idx_o  (idx)
  );

  always_comb begin
    if (p_q == '0) begin
      last_cnt = CNT_W'(P0_SLOT - 1);
    end else begin
      last_cnt = ((CNT_W'(p_q) + CNT_W'(1)) << FRAC_W)
               + CNT_W'(frac_extra) + CNT_W'(mod_extra) - CNT_W'(1);
    end
  end

  // a start pulse wins over a coinciding strobe
  assign tick    = active_q && en_i && !frame_start_i;
  assign bit_end = tick && (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      p_q      <= '0;
      m_q      <= '0;
      u_q      <= '0;
      len_q    <= IDX_W'(3);
      cnt_q    <= '0;
    end else if (frame_start_i) begin
      active_q <= 1'b1;
      p_q      <= presc_i;
      m_q      <= frac_i;
      u_q      <= mod_i;
      len_q    <= frame_len_i;
      cnt_q    <= '0;
    end else if (tick) begin
      cnt_q    <= bit_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_end_o = bit_end;
  assign bit_idx_o = idx;

  assert_p0_slot_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && p_q == '0) |-> (cnt_q < CNT_W'(P0_SLOT)));
  assert_cfg_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable({p_q, m_q, u_q, len_q}));
  assert_start_restarts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (cnt_q == '0 && bit_idx_o == '0 && !$past(bit_end_o)));
  assert_stall_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !frame_start_i) |-> (!bit_end_o ##1 $stable(cnt_q)));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> (!bit_end_o && bit_idx_o == '0));
endmodule

// File: tb/test_sfrac_baud_gen.sv
module test_sfrac_baud_gen;
  localparam int PW = 8;
  localparam int IW = 4;
  localparam int NV = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic          fs = 1'b0;
  logic [PW-1:0] presc = '0;
  logic [3:0]    frac = '0;
  logic [2:0]    modc = '0;
  logic [IW-1:0] flen = 4'd3;
  logic          bit_end;
  logic [IW-1:0] bit_idx;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sfrac_baud_gen #(.PRESC_W(PW), .IDX_W(IW)) i_sfrac_baud_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .frame_start_i(fs),
    .presc_i      (presc),
    .frac_i       (frac),
    .mod_i        (modc),
    .frame_len_i  (flen),
    .bit_end_o    (bit_end),
    .bit_idx_o    (bit_idx)
  );

  // {P, M, U, L}
  localparam logic [19:0] VEC [NV] = '{
    {8'd1, 4'd0,  4'd0, 4'd3}, {8'd1, 4'd15, 4'd0, 4'd10}, {8'd1, 4'd0,  4'd0, 4'd13},
    {8'd1, 4'd1,  4'd1, 4'd3}, {8'd1, 4'd14, 4'd1, 4'd10}, {8'd1, 4'd5,  4'd1, 4'd13},
    {8'd1, 4'd2,  4'd2, 4'd3}, {8'd1, 4'd13, 4'd2, 4'd10}, {8'd1, 4'd10, 4'd2, 4'd13},
    {8'd1, 4'd3,  4'd3, 4'd3}, {8'd1, 4'd12, 4'd3, 4'd10}, {8'd1, 4'd15, 4'd3, 4'd13},
    {8'd1, 4'd4,  4'd4, 4'd3}, {8'd1, 4'd11, 4'd4, 4'd10}, {8'd1, 4'd4,  4'd4, 4'd13},
    {8'd1, 4'd5,  4'd5, 4'd3}, {8'd1, 4'd10, 4'd5, 4'd10}, {8'd1, 4'd9,  4'd5, 4'd13},
    {8'd1, 4'd6,  4'd6, 4'd3}, {8'd1, 4'd9,  4'd6, 4'd10}, {8'd1, 4'd14, 4'd6, 4'd13},
    {8'd1, 4'd7,  4'd7, 4'd3}, {8'd1, 4'd8,  4'd7, 4'd10}, {8'd1, 4'd3,  4'd7, 4'd13},
    {8'd0, 4'd5,  4'd7, 4'd13}, {8'd2, 4'd0, 4'd0, 4'd10}, {8'd3, 4'd0,  4'd5, 4'd3}
  };

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // model of the position table, one test per position
  function automatic int mod_hit(input int u, input int e);
    case (e)
      0, 8:    return int'(u >= 1);
      1, 9:    return int'(u >= 5);
      2:       return int'(u >= 3);
      3:       return int'(u >= 7);
      4:       return int'(u >= 2);
      5:       return int'(u >= 6);
      6:       return int'(u >= 4);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(input int p, input int m, input int u, input int len, input int j);
    int slot = (j < len) ? j : len - 1;
    int e    = (slot < 10) ? slot : slot - 8;
    if (p == 0) return 32;
    return 16 * (p + 1) + int'(((j + 1) * m) / 16 > (j * m) / 16) + mod_hit(u, e);
  endfunction

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk); #1;
      n++;
    end while (!bit_end && n < 5000);
  endtask

  task automatic start_frame(input int p, input int m, input int u, input int len);
    @(negedge clk);
    presc = PW'(p); frac = 4'(m); modc = 3'(u); flen = IW'(len);
    fs = 1'b1;
    @(posedge clk); #1;
    fs = 1'b0;
  endtask

  task automatic run_frame(input int p, input int m, input int u, input int len);
    int n;
    string req;
    start_frame(p, m, u, len);
    for (int j = 0; j <= len; j++) begin
      int eidx = (j < len) ? j : len - 1;
      if (p == 0)                  req = "R2";
      else if (j >= len)           req = "R6";
      else if (j >= 10)            req = "R5";
      else if (u != 0)             req = "R4";
      else if (m != 0)             req = "R3";
      else                         req = "R1";
      wait_strobe(n);
      chk(n == exp_len(p, m, u, len, j), req, n, exp_len(p, m, u, len, j));
      chk(int'(bit_idx) == eidx, "R6", int'(bit_idx), eidx);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int n;
    // R10: reset and idle
    repeat (3) @(negedge clk);
    chk(bit_end == 1'b0, "R10", int'(bit_end), 0);
    chk(bit_idx == '0, "R10", int'(bit_idx), 0);
    rst_n = 1'b1;
    n = 0;
    repeat (40) begin
      @(negedge clk); #1;
      if (bit_end) n++;
    end
    chk(n == 0, "R10", n, 0);
    chk(bit_idx == '0, "R10", int'(bit_idx), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_frame(int'(VEC[v][19:12]), int'(VEC[v][11:8]), int'(VEC[v][7:4]), int'(VEC[v][3:0]));
    end

    // R7: mid-frame config change ignored
    start_frame(1, 0, 0, 3);
    wait_strobe(n);
    chk(n == 32, "R7", n, 32);
    presc = 8'd3; frac = 4'd15; modc = 3'd7;
    wait_strobe(n);
    chk(n == 32, "R7", n, 32);
    chk(bit_idx == 4'd1, "R7", int'(bit_idx), 1);

    // R9: stall with enable low
    start_frame(1, 0, 0, 3);
    @(negedge clk); en = 1'b0;
    n = 0;
    repeat (5) begin
      @(negedge clk); #1;
      if (bit_end) n++;
    end
    chk(n == 0, "R9", n, 0);
    en = 1'b1;
    wait_strobe(n);
    chk(n == 31, "R9", n, 31);

    // R8: start pulse lands in the strobe cycle
    start_frame(1, 0, 0, 3);
    wait_strobe(n);
    repeat (31) @(negedge clk);
    @(negedge clk);
    presc = 8'd2; fs = 1'b1;
    #1;
    chk(bit_end == 1'b0, "R8", int'(bit_end), 0);
    @(posedge clk); #1;
    fs = 1'b0;
    chk(bit_idx == '0, "R8", int'(bit_idx), 0);
    wait_strobe(n);
    chk(n == 48, "R8", n, 48);

    summary();
    $finish;
  end
endmodule